// File: doc/BRIEF.md
# Guarded Reconfiguration and Configuration Read-Back Sequencer

This block lets software do two things through a small register window. It can make the device reload itself from a flash image. It can also fetch the 16-bit contents of one internal configuration register. Both jobs are carried out as a series of 16-bit words issued on an abstract command port, which uses a valid/ready handshake. The read-back result comes back on a separate response strobe and is stored with a valid flag.

Two 32-bit words hold flash locations, one for the main image and one for the fallback image. In each word, the top byte is the flash read (or fast-read) opcode and the low 24 bits are the byte address. A reload fires only if an unlock bit was set by an earlier write. The unlock bit is consumed by every reload attempt.

A watchdog counts cycles without progress while a sequence is running. When the count reaches its limit, the watchdog forces the sequencer back to idle and sets a sticky timeout flag. Software clears that flag with a write of one.

Top module: `cfgseq_top`

## Requirements
- R1: After reset, all four registers read zero and `cmd_valid` is low. Register select values: 0 = control, 1 = status, 2 = fallback image word, 3 = main image word.
- R2: A control write with bit 17 (trigger) set starts a reload only if bit 16 (unlock) already read 1 before that write. A trigger that arrives with unlock clear, including one in the same write that sets unlock, issues no word and leaves bit 17 reading 0.
- R3: A reload issues these words in order: 16'hAA99, 16'h5566, main word [31:16], main word [15:0], fallback word [31:16], fallback word [15:0], 16'h000E, and then NOOP_COUNT copies of 16'h2000.
- R4: Control bit 17 reads 1 while a reload is running. When the reload finishes or is aborted by the watchdog, both bit 17 and bit 16 read 0.
- R5: A control write with bit 6 set starts a read-back of the register addressed by bits 5..0 of the same write. It issues 16'hAA99, 16'h5566, 16'h2801 OR (address shifted left by 5), then NOOP_COUNT copies of 16'h2000. After that it waits for `rsp_valid`.
- R6: The status valid bit (bit 16) drops when a read-back starts. When `rsp_valid` arrives in the wait phase, the bit rises and `rsp_data` appears in status bits 15..0.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds its value. A word advances only on a cycle where both are high.
- R8: If a running sequence makes no progress for WDOG_LIMIT cycles, the sequencer returns to idle and status bit 17 (timeout) rises. Progress means a word is accepted or a response arrives.
- R9: Writing 1 to status bit 17 clears the timeout flag and writing 0 leaves it unchanged. A watchdog expiry in the same cycle as a clear wins.
- R10: While a sequence is running, new reload or read-back requests are ignored, and so are writes to the image words. If one control write requests both a reload and a read-back, only the reload runs.
- R11: The two image words read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register, combinational |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Command port accepts the word |
| cmd_data | output | 16 | Command word |
| rsp_valid | input | 1 | Read-back response strobe |
| rsp_data | input | 16 | Read-back response value |

## Verification
The two functions that can collide in one cycle are the reload start and the read-back start, because a single control write may request both. The bench sets unlock first and then writes trigger, read request and an address together. It then judges the result by the words that appear on the command port: exactly the reload series must appear, with no read header. It also checks that the status valid bit keeps its previous value. A second collision, a watchdog expiry against a software clear of the timeout flag, is left to the ordering rule stated in R9.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int WORD_W  = 32;
  localparam int CMD_W   = 16;
  localparam int CFG_AW  = 6;
  localparam int IMG_W   = 16;
  localparam int SEL_W   = 2;

  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_GOLD = 2'd2;
  localparam logic [SEL_W-1:0] SEL_MAIN = 2'd3;

  localparam int CTL_RDREQ  = 6;
  localparam int CTL_UNLOCK = 16;
  localparam int CTL_TRIG   = 17;
  localparam int STS_VALID  = 16;
  localparam int STS_TMO    = 17;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECONF = 2'd1,
    ST_READ   = 2'd2,
    ST_WAIT   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cfgseq_regs.sv
module cfgseq_regs
  import cfgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              seq_idle,
  input  logic              reconf_end,
  input  logic              rd_capture,
  input  logic [IMG_W-1:0]  rd_word,
  input  logic              wd_fire,
  output logic              go_reconf,
  output logic              go_read,
  output logic [CFG_AW-1:0] rd_addr,
  output logic [WORD_W-1:0] gold_word,
  output logic [WORD_W-1:0] main_word,
  output logic              unlock_o,
  output logic              valid_o,
  output logic              tmo_o
);
  logic ctl_wr, stat_wr, gold_wr, main_wr;

  logic              unlock_q, unlock_d, unlock_en;
  logic              trig_q, trig_d, trig_en;
  logic [CFG_AW-1:0] cfga_q;
  logic              valid_q, valid_d, valid_en;
  logic [IMG_W-1:0]  img_q;
  logic              tmo_q, tmo_d, tmo_en;
  logic [WORD_W-1:0] gold_q, main_q;

  always_comb begin
    ctl_wr  = reg_wr && (reg_addr == SEL_CTRL);
    stat_wr = reg_wr && (reg_addr == SEL_STAT);
    gold_wr = reg_wr && (reg_addr == SEL_GOLD) && seq_idle;
    main_wr = reg_wr && (reg_addr == SEL_MAIN) && seq_idle;

    go_reconf = ctl_wr && reg_wdata[CTL_TRIG] && unlock_q && seq_idle;
    go_read   = ctl_wr && reg_wdata[CTL_RDREQ] && seq_idle && !go_reconf;
    rd_addr   = ctl_wr ? reg_wdata[CFG_AW-1:0] : cfga_q;

    unlock_en = ctl_wr || reconf_end;
    unlock_d  = reconf_end ? 1'b0 : reg_wdata[CTL_UNLOCK];

    trig_en   = go_reconf || reconf_end;
    trig_d    = go_reconf;

    valid_en  = go_read || rd_capture;
    valid_d   = !go_read;

    tmo_en    = wd_fire || (stat_wr && reg_wdata[STS_TMO]);
    tmo_d     = wd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      trig_q   <= 1'b0;
      cfga_q   <= '0;
      valid_q  <= 1'b0;
      img_q    <= '0;
      tmo_q    <= 1'b0;
      gold_q   <= '0;
      main_q   <= '0;
    end else begin
      if (unlock_en)  unlock_q <= unlock_d;
      if (trig_en)    trig_q   <= trig_d;
      if (ctl_wr)     cfga_q   <= reg_wdata[CFG_AW-1:0];
      if (valid_en)   valid_q  <= valid_d;
      if (rd_capture) img_q    <= rd_word;
      if (tmo_en)     tmo_q    <= tmo_d;
      if (gold_wr)    gold_q   <= reg_wdata;
      if (main_wr)    main_q   <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_CTRL: begin
        reg_rdata[CFG_AW-1:0] = cfga_q;
        reg_rdata[CTL_UNLOCK] = unlock_q;
        reg_rdata[CTL_TRIG]   = trig_q;
      end
      SEL_STAT: begin
        reg_rdata[IMG_W-1:0] = img_q;
        reg_rdata[STS_VALID] = valid_q;
        reg_rdata[STS_TMO]   = tmo_q;
      end
      SEL_GOLD: reg_rdata = gold_q;
      default:  reg_rdata = main_q;
    endcase
  end

  assign gold_word = gold_q;
  assign main_word = main_q;
  assign unlock_o  = unlock_q;
  assign valid_o   = valid_q;
  assign tmo_o     = tmo_q;
endmodule

// File: rtl/cfgseq_wdog.sv
module cfgseq_wdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic kick,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    fire   = active && !kick && (cnt_q == CW'(LIMIT - 1));
    cnt_en = 1'b1;
    if (!active || kick || fire) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
    if (cnt_d == cnt_q) cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
#(
  parameter int          NOOP_COUNT = 2,
  parameter logic [15:0] SYNC_W0    = 16'hAA99,
  parameter logic [15:0] SYNC_W1    = 16'h5566,
  parameter logic [15:0] RD_HDR     = 16'h2801,
  parameter logic [15:0] RECONF_CMD = 16'h000E,
  parameter logic [15:0] NOOP_WORD  = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_reconf,
  input  logic              go_read,
  input  logic [CFG_AW-1:0] rd_addr,
  input  logic [WORD_W-1:0] gold_word,
  input  logic [WORD_W-1:0] main_word,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic [IMG_W-1:0]  rsp_data,
  input  logic              wd_fire,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              seq_idle,
  output logic              seq_active,
  output logic              reconf_end,
  output logic              rd_capture,
  output logic [IMG_W-1:0]  rd_word,
  output logic              kick
);
  localparam int RECONF_LEN = 7 + NOOP_COUNT;
  localparam int READ_LEN   = 3 + NOOP_COUNT;
  localparam int IDX_W      = $clog2(RECONF_LEN + 1);

  seq_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CFG_AW-1:0] addr_q;
  logic              seq_en, addr_en, accept, last_word;

  always_comb begin
    cmd_valid  = (state_q == ST_RECONF) || (state_q == ST_READ);
    accept     = cmd_valid && cmd_ready;
    last_word  = (state_q == ST_RECONF) ? (idx_q == IDX_W'(RECONF_LEN - 1))
                                        : (idx_q == IDX_W'(READ_LEN - 1));
    kick       = accept || ((state_q == ST_WAIT) && rsp_valid);
    seq_active = (state_q != ST_IDLE);
    seq_idle   = !seq_active;
    rd_word    = rsp_data;
  end

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    addr_en    = 1'b0;
    reconf_end = 1'b0;
    rd_capture = 1'b0;
    if (wd_fire) begin
      state_d    = ST_IDLE;
      idx_d      = '0;
      reconf_end = (state_q == ST_RECONF);
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_reconf) begin
            state_d = ST_RECONF;
            idx_d   = '0;
          end else if (go_read) begin
            state_d = ST_READ;
            idx_d   = '0;
            addr_en = 1'b1;
          end
        end
        ST_RECONF: begin
          if (accept) begin
            if (last_word) begin
              state_d    = ST_IDLE;
              idx_d      = '0;
              reconf_end = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (accept) begin
            if (last_word) begin
              state_d = ST_WAIT;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        default: begin
          if (rsp_valid) begin
            state_d    = ST_IDLE;
            rd_capture = 1'b1;
          end
        end
      endcase
    end
    seq_en = (state_d != state_q) || (idx_d != idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      if (seq_en) begin
        state_q <= state_d;
        idx_q   <= idx_d;
      end
      if (addr_en) addr_q <= rd_addr;
    end
  end

  always_comb begin
    cmd_data = '0;
    if (state_q == ST_RECONF) begin
      case (idx_q)
        IDX_W'(0): cmd_data = SYNC_W0;
        IDX_W'(1): cmd_data = SYNC_W1;
        IDX_W'(2): cmd_data = main_word[31:16];
        IDX_W'(3): cmd_data = main_word[15:0];
        IDX_W'(4): cmd_data = gold_word[31:16];
        IDX_W'(5): cmd_data = gold_word[15:0];
        IDX_W'(6): cmd_data = RECONF_CMD;
        default:   cmd_data = NOOP_WORD;
      endcase
    end else if (state_q == ST_READ) begin
      case (idx_q)
        IDX_W'(0): cmd_data = SYNC_W0;
        IDX_W'(1): cmd_data = SYNC_W1;
        IDX_W'(2): cmd_data = RD_HDR | (CMD_W'(addr_q) << 5);
        default:   cmd_data = NOOP_WORD;
      endcase
    end
  end
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top #(
  parameter int          WDOG_LIMIT = 1024,
  parameter int          NOOP_COUNT = 2,
  parameter logic [15:0] SYNC_W0    = 16'hAA99,
  parameter logic [15:0] SYNC_W1    = 16'h5566,
  parameter logic [15:0] RD_HDR     = 16'h2801,
  parameter logic [15:0] RECONF_CMD = 16'h000E,
  parameter logic [15:0] NOOP_WORD  = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [15:0] cmd_data,
  input  logic        rsp_valid,
  input  logic [15:0] rsp_data
);
  import cfgseq_pkg::*;

  logic              seq_idle, seq_active, reconf_end, rd_capture, kick, wd_fire;
  logic              go_reconf, go_read, ctl_unlock, img_valid, tmo_flag;
  logic [IMG_W-1:0]  rd_word;
  logic [CFG_AW-1:0] rd_addr;
  logic [WORD_W-1:0] gold_word, main_word;

  cfgseq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_idle(seq_idle), .reconf_end(reconf_end), .rd_capture(rd_capture), .rd_word(rd_word),
    .wd_fire(wd_fire), .go_reconf(go_reconf), .go_read(go_read), .rd_addr(rd_addr),
    .gold_word(gold_word), .main_word(main_word),
    .unlock_o(ctl_unlock), .valid_o(img_valid), .tmo_o(tmo_flag)
  );

  cfgseq_fsm #(
    .NOOP_COUNT(NOOP_COUNT), .SYNC_W0(SYNC_W0), .SYNC_W1(SYNC_W1),
    .RD_HDR(RD_HDR), .RECONF_CMD(RECONF_CMD), .NOOP_WORD(NOOP_WORD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go_reconf(go_reconf), .go_read(go_read), .rd_addr(rd_addr),
    .gold_word(gold_word), .main_word(main_word),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wd_fire(wd_fire),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .seq_idle(seq_idle), .seq_active(seq_active),
    .reconf_end(reconf_end), .rd_capture(rd_capture), .rd_word(rd_word), .kick(kick)
  );

  cfgseq_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .active(seq_active), .kick(kick), .fire(wd_fire)
  );
endmodule

// File: rtl/cfgseq_top_chk.sv
module cfgseq_top_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [15:0] cmd_data,
  input logic        ctl_unlock,
  input logic        go_read,
  input logic        img_valid,
  input logic        wd_fire,
  input logic        tmo_flag,
  input logic        reconf_end
);
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !wd_fire) |=> (cmd_valid && $stable(cmd_data)));

  p_locked_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[17] && !reg_wdata[6] && !ctl_unlock && !cmd_valid)
      |=> !cmd_valid);

  p_unlock_spent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_end |=> !ctl_unlock);

  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_read |=> !img_valid);

  p_tmo_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> tmo_flag);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> !cmd_valid);
endmodule

bind cfgseq_top cfgseq_top_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .ctl_unlock(ctl_unlock), .go_read(go_read), .img_valid(img_valid),
  .wd_fire(wd_fire), .tmo_flag(tmo_flag), .reconf_end(reconf_end)
);

// File: tb/cfgseq_top_tb_top.sv
module cfgseq_top_tb_top;
  localparam int LIMIT      = 40;
  localparam int NOOPS      = 2;
  localparam int RECONF_LEN = 7 + NOOPS;
  localparam int READ_LEN   = 3 + NOOPS;

  logic        clk, rst_n, reg_wr, cmd_valid, cmd_ready, rsp_valid;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] cmd_data, rsp_data;

  int total = 0, bad = 0;
  int ready_mode = 0;
  logic [15:0] cap [0:511];
  int cap_n = 0;
  logic [31:0] gold_m, main_m, v;

  cfgseq_top #(.WDOG_LIMIT(LIMIT), .NOOP_COUNT(NOOPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: cmd_ready = 1'b1;
      1: cmd_ready = (($urandom % 10) < 7);
      default: cmd_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready && cap_n < 512) begin
      cap[cap_n] = cmd_data;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [15:0] exp_reconf(int i, logic [31:0] mw, logic [31:0] gw);
    case (i)
      0: return 16'hAA99;
      1: return 16'h5566;
      2: return mw[31:16];
      3: return mw[15:0];
      4: return gw[31:16];
      5: return gw[15:0];
      6: return 16'h000E;
      default: return 16'h2000;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(int i, logic [5:0] a);
    case (i)
      0: return 16'hAA99;
      1: return 16'h5566;
      2: return 16'h2801 | (16'(a) << 5);
      default: return 16'h2000;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_words(int target);
    for (int g = 0; g < 2000 && cap_n < target; g++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic respond(logic [15:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_reconf(string tag);
    int base;
    base = cap_n;
    wr(2'd0, 32'h0001_0000);
    wr(2'd0, 32'h0002_0000);
    wait_words(base + RECONF_LEN);
    chk(tag, 32'(cap_n - base), RECONF_LEN);
    for (int i = 0; i < RECONF_LEN; i++)
      chk("R3 word", 32'(cap[base + i]), 32'(exp_reconf(i, main_m, gold_m)));
  endtask

  initial begin
    $urandom(1234);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    rsp_valid = 1'b0; rsp_data = '0; cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 reg zero", v, 32'h0);
    end
    chk("R1 cmd_valid low", 32'(cmd_valid), 0);

    gold_m = $urandom; main_m = $urandom;
    wr(2'd2, gold_m); wr(2'd3, main_m);
    rd(2'd2, v); chk("R11 fallback word", v, gold_m);
    rd(2'd3, v); chk("R11 main word", v, main_m);

    begin : locked
      int base;
      base = cap_n;
      wr(2'd0, 32'h0002_0000);
      repeat (4) @(negedge clk);
      chk("R2 locked trigger no words", 32'(cap_n - base), 0);
      rd(2'd0, v); chk("R2 locked trigger bit", 32'(v[17]), 0);
      wr(2'd0, 32'h0003_0000);
      repeat (4) @(negedge clk);
      chk("R2 same-write unlock no words", 32'(cap_n - base), 0);
      rd(2'd0, v); chk("R2 unlock set, trigger clear", 32'(v[17:16]), 32'b01);
    end

    begin : active_readback
      int base;
      base = cap_n;
      ready_mode = 2;
      wr(2'd0, 32'h0001_0000);
      wr(2'd0, 32'h0002_0000);
      rd(2'd0, v); chk("R4 trigger reads 1 while busy", 32'(v[17]), 1);
      wr(2'd0, 32'h0001_0045);
      wr(2'd3, 32'hDEAD_BEEF);
      ready_mode = 1;
      wait_words(base + RECONF_LEN);
      repeat (4) @(negedge clk);
      chk("R10 busy request ignored", 32'(cap_n - base), RECONF_LEN);
      for (int i = 0; i < RECONF_LEN; i++)
        chk("R3 word under stalls", 32'(cap[base + i]), 32'(exp_reconf(i, main_m, gold_m)));
      rd(2'd3, v); chk("R10 image write ignored while busy", v, main_m);
      rd(2'd0, v); chk("R4 bits cleared after reload", 32'(v[17:16]), 0);
    end

    for (int k = 0; k < 5; k++) begin
      gold_m = $urandom; main_m = $urandom;
      wr(2'd2, gold_m); wr(2'd3, main_m);
      run_reconf("R3 count");
      rd(2'd0, v); chk("R4 bits cleared", 32'(v[17:16]), 0);
    end

    for (int k = 0; k < 6; k++) begin
      int base;
      logic [5:0] a;
      logic [15:0] d;
      a = 6'($urandom); d = 16'($urandom);
      base = cap_n;
      wr(2'd0, 32'h0000_0040 | 32'(a));
      rd(2'd1, v); chk("R6 valid dropped at start", 32'(v[16]), 0);
      wait_words(base + READ_LEN);
      for (int i = 0; i < READ_LEN; i++)
        chk("R5 word", 32'(cap[base + i]), 32'(exp_read(i, a)));
      respond(d);
      rd(2'd1, v); chk("R6 image and valid", v[16:0], {1'b1, d});
      ready_mode = 1;
    end

    begin : both
      int base;
      ready_mode = 0;
      base = cap_n;
      wr(2'd0, 32'h0001_0000);
      wr(2'd0, 32'h0002_0040 | 32'h15);
      wait_words(base + RECONF_LEN);
      repeat (4) @(negedge clk);
      chk("R10 only reload words", 32'(cap_n - base), RECONF_LEN);
      chk("R10 first word third is main", 32'(cap[base + 2]), 32'(main_m[31:16]));
      rd(2'd1, v); chk("R10 valid untouched", 32'(v[16]), 1);
    end

    begin : wd_reload
      ready_mode = 2;
      wr(2'd0, 32'h0001_0000);
      @(negedge clk);
      wr(2'd0, 32'h0002_0000);
      repeat (LIMIT - 1) @(negedge clk);
      rd(2'd1, v); chk("R8 no timeout before limit", 32'(v[17]), 0);
      @(negedge clk);
      rd(2'd1, v); chk("R8 timeout at limit", 32'(v[17]), 1);
      chk("R8 idle after abort", 32'(cmd_valid), 0);
      rd(2'd0, v); chk("R4 bits cleared after abort", 32'(v[17:16]), 0);
      ready_mode = 0;
      wr(2'd1, 32'h0);
      rd(2'd1, v); chk("R9 write 0 keeps flag", 32'(v[17]), 1);
      wr(2'd1, 32'h0002_0000);
      rd(2'd1, v); chk("R9 write 1 clears flag", 32'(v[17]), 0);
    end

    begin : wd_read
      wr(2'd0, 32'h0000_0047);
      repeat (LIMIT + READ_LEN + 4) @(negedge clk);
      rd(2'd1, v); chk("R8 read wait timeout", 32'(v[17:16]), 32'b10);
      wr(2'd1, 32'h0002_0000);
      rd(2'd1, v); chk("R9 cleared again", 32'(v[17]), 0);
    end

    gold_m = $urandom; main_m = $urandom;
    wr(2'd2, gold_m); wr(2'd3, main_m);
    ready_mode = 1;
    run_reconf("R7 count with stalls");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule